// File: doc/BRIEF.md
# Threshold-Driven Transfer Request Controller

This block sits between a host bus and a disk-side data engine. It holds a 16-byte FIFO and decides when to ask the host to move data. The request points depend on a programmable threshold and on the direction of the transfer. In the disk-to-host direction (`dir_wr_i` = 0) the disk engine fills the FIFO and the host empties it. In the host-to-disk direction (`dir_wr_i` = 1) the host fills the FIFO and the disk engine empties it. The request is shown in one of two ways. Without DMA, `irq_o` and the ready status bit `rqm_o` both carry it. With DMA, only `drq_o` carries it.

A transfer runs through four named phases. `PH_IDLE` is the state after reset. A pulse on `exec_start_i` moves the block to `PH_EXEC` (transition *start*); this also empties the FIFO and clears the status from the previous transfer. `PH_EXEC` moves to `PH_FINISH` (transition *sector close*) when the disk side passes the last byte of a sector and a stop condition is pending. The stop conditions are a terminal count, a host overrun or underrun, or an end-of-track marker. `PH_FINISH` lets the FIFO drain and moves to `PH_RESULT` (transition *drained*) in the cycle after the FIFO becomes empty. `PH_RESULT` holds the termination status until another *start* moves the block back to `PH_EXEC`.

Top module: `thr_xfer_ctrl`

## Requirements
- R1: The FIFO holds 16 bytes in arrival order. A push is taken only when the FIFO is not full. A pop is taken only when it is not empty. `host_rdata_o` and `disk_rdata_o` always show the oldest byte.
- R2: In the disk-to-host direction the request is set on the clock edge at which the occupancy becomes at least 16 minus `thresh_i`. A threshold of 0 therefore means the FIFO must be full.
- R3: In the disk-to-host direction, an accepted disk push with `sector_last_i` high sets the request at that edge, whatever the occupancy.
- R4: In the disk-to-host direction the request is cleared only at the edge at which the occupancy becomes 0. It holds at any other level.
- R5: In the host-to-disk direction the request is high from the first cycle of `PH_EXEC`. It is cleared at the edge at which the FIFO becomes full.
- R6: In the host-to-disk direction the request is set again at the edge at which the occupancy drops to `thresh_i` or below.
- R7: When `dma_mode_i` = 0, `irq_o` and `rqm_o` both equal the request and `drq_o` is 0. When `dma_mode_i` = 1, `drq_o` equals the request and `irq_o` and `rqm_o` are 0. All three are 0 in `PH_IDLE` and in `PH_RESULT`.
- R8: `tc_i` is taken only in `PH_EXEC` with `dma_mode_i` = 1. After it, the transfer closes at the next sector-last disk strobe with status 2'b01 (normal). Without DMA, `tc_i` has no effect.
- R9: A host write while the FIFO is full, or a host read while it is empty, in `PH_EXEC` on the active side, is ignored. It sets the sticky flag `ovr_o`, and the transfer closes at the next sector-last disk strobe with status 2'b10 (abnormal).
- R10: A sector-last disk strobe while `track_end_i` is high closes the transfer. The status is 2'b10 unless a terminal count was taken earlier.
- R11: `PH_RESULT` is entered in the cycle after the FIFO becomes empty in `PH_FINISH`. `result_o` is then high and `status_o` is non-zero and steady. The next *start* clears `status_o` and `ovr_o` and empties the FIFO.
- R12: After reset the block is in `PH_IDLE`: every request output is 0, `result_o` is 0, `ovr_o` is 0 and `status_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_start_i | input | 1 | Start pulse for the execution phase |
| dir_wr_i | input | 1 | 0: disk to host, 1: host to disk |
| dma_mode_i | input | 1 | 1: DMA request line, 0: interrupt and ready status |
| thresh_i | input | 4 | Request threshold |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Oldest FIFO byte, host side |
| disk_wr_i | input | 1 | Disk-side write strobe |
| disk_wdata_i | input | 8 | Disk-side write byte |
| disk_rd_i | input | 1 | Disk-side read strobe |
| disk_rdata_o | output | 8 | Oldest FIFO byte, disk side |
| sector_last_i | input | 1 | Qualifies the disk strobe as the last byte of a sector |
| track_end_i | input | 1 | Current sector is the last one of the track |
| tc_i | input | 1 | Terminal count |
| irq_o | output | 1 | Interrupt request (without DMA) |
| rqm_o | output | 1 | Ready status bit (without DMA) |
| drq_o | output | 1 | DMA request |
| result_o | output | 1 | Result phase active |
| status_o | output | 2 | Termination status: 00 none, 01 normal, 10 abnormal |
| ovr_o | output | 1 | Sticky overrun/underrun flag |

## Verification
The request, the phase, the status and the flag are all registers. A strobe presented before a rising edge therefore shows on `irq_o`, `rqm_o`, `drq_o`, `result_o`, `status_o` and `ovr_o` exactly one edge later. The request outputs also follow `dma_mode_i` with no delay. The head byte on the two read-data ports changes in the same cycle as the occupancy. The bench drives each cycle's inputs at the falling edge. Its reference functions then step the expected state through one rising edge, and it compares every output at the next falling edge. Each comparison is therefore made exactly one edge after the stimulus it depends on.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXEC   = 2'd1,
        PH_FINISH = 2'd2,
        PH_RESULT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        TS_NONE     = 2'd0,
        TS_NORMAL   = 2'd1,
        TS_ABNORMAL = 2'd2
    } term_e;

endpackage

// File: rtl/xfr_fifo.sv
module xfr_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          push_ok_o,
    output logic          pop_ok_o,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o    = (cnt_q == CW'(DEPTH));
    assign empty_o   = (cnt_q == '0);
    assign push_ok_o = push_i && !full_o;
    assign pop_ok_o  = pop_i && !empty_o;
    assign head_o    = mem[rd_ptr];
    assign cnt_o     = cnt_q;

    always_comb begin
        if (flush_i) begin
            cnt_next_o = '0;
        end else begin
            cnt_next_o = cnt_q + CW'(push_ok_o) - CW'(pop_ok_o);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok_o) wr_ptr <= bump(wr_ptr);
            if (pop_ok_o)  rd_ptr <= bump(rd_ptr);
            cnt_q <= cnt_next_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok_o && !flush_i) mem[wr_ptr] <= push_data_i;
    end

endmodule

// File: rtl/xfr_req_gen.sv
module xfr_req_gen #(
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          enter_i,
    input  logic          dir_wr_i,
    input  logic [TW-1:0] thresh_i,
    input  logic [CW-1:0] cnt_next_i,
    input  logic          last_push_i,
    output logic          req_o
);

    logic          req_q, req_d;
    logic [CW-1:0] trig_lvl;

    // disk-to-host trigger: DEPTH minus threshold
    assign trig_lvl = CW'(DEPTH) - CW'(thresh_i);

    always_comb begin
        req_d = req_q;
        if (enter_i) begin
            req_d = dir_wr_i;
        end else if (!dir_wr_i) begin
            if (cnt_next_i == '0) begin
                req_d = 1'b0;
            end else if ((cnt_next_i >= trig_lvl) || last_push_i) begin
                req_d = 1'b1;
            end
        end else begin
            if (cnt_next_i == CW'(DEPTH)) begin
                req_d = 1'b0;
            end else if (cnt_next_i <= CW'(thresh_i)) begin
                req_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= req_d;
    end

    assign req_o = req_q;

endmodule

// File: rtl/xfr_phase_fsm.sv
module xfr_phase_fsm
    import xfr_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   exec_start_i,
    input  logic   tc_take_i,
    input  logic   viol_i,
    input  logic   sec_end_i,
    input  logic   track_end_i,
    input  logic   drained_i,
    output phase_e phase_o,
    output term_e  status_o,
    output logic   ovr_o,
    output logic   enter_o
);

    phase_e ph_q, ph_d;
    term_e  st_q, st_d;
    logic   tcs_q, tcs_d;
    logic   ovr_q, ovr_d;
    logic   tc_all, ab_all;

    assign enter_o = exec_start_i && ((ph_q == PH_IDLE) || (ph_q == PH_RESULT));
    assign tc_all  = tcs_q || tc_take_i;
    assign ab_all  = ovr_q || viol_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q  <= PH_IDLE;
            st_q  <= TS_NONE;
            tcs_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            st_q  <= st_d;
            tcs_q <= tcs_d;
            ovr_q <= ovr_d;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        st_d  = st_q;
        tcs_d = tcs_q;
        ovr_d = ovr_q;
        unique case (ph_q)
            PH_IDLE, PH_RESULT: begin
                if (exec_start_i) begin
                    ph_d  = PH_EXEC;
                    st_d  = TS_NONE;
                    tcs_d = 1'b0;
                    ovr_d = 1'b0;
                end
            end
            PH_EXEC: begin
                tcs_d = tc_all;
                ovr_d = ab_all;
                if (sec_end_i && (tc_all || ab_all || track_end_i)) begin
                    ph_d = PH_FINISH;
                    st_d = (ab_all || (track_end_i && !tc_all)) ? TS_ABNORMAL : TS_NORMAL;
                end
            end
            PH_FINISH: begin
                if (drained_i) ph_d = PH_RESULT;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    assign phase_o  = ph_q;
    assign status_o = st_q;
    assign ovr_o    = ovr_q;

endmodule

// File: rtl/thr_xfer_ctrl.sv
module thr_xfer_ctrl
    import xfr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          exec_start_i,
    input  logic          dir_wr_i,
    input  logic          dma_mode_i,
    input  logic [TW-1:0] thresh_i,
    input  logic          host_wr_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic          host_rd_i,
    output logic [DW-1:0] host_rdata_o,
    input  logic          disk_wr_i,
    input  logic [DW-1:0] disk_wdata_i,
    input  logic          disk_rd_i,
    output logic [DW-1:0] disk_rdata_o,
    input  logic          sector_last_i,
    input  logic          track_end_i,
    input  logic          tc_i,
    output logic          irq_o,
    output logic          rqm_o,
    output logic          drq_o,
    output logic          result_o,
    output logic [1:0]    status_o,
    output logic          ovr_o
);

    phase_e        phase;
    term_e         status;
    logic          enter, in_exec, xfer_act;
    logic          push_req, pop_req, push_ok, pop_ok;
    logic          full, empty, viol, sec_end, last_push, tc_take, req;
    logic [DW-1:0] push_data, head;
    logic [CW-1:0] fill_cnt, cnt_next;

    assign in_exec  = (phase == PH_EXEC);
    assign xfer_act = in_exec || (phase == PH_FINISH);

    assign push_req  = in_exec && (dir_wr_i ? host_wr_i : disk_wr_i);
    assign push_data = dir_wr_i ? host_wdata_i : disk_wdata_i;
    assign pop_req   = xfer_act && (dir_wr_i ? disk_rd_i : host_rd_i);

    assign viol      = in_exec && (dir_wr_i ? (host_wr_i && full) : (host_rd_i && empty));
    assign sec_end   = sector_last_i && (dir_wr_i ? pop_ok : push_ok);
    assign last_push = !dir_wr_i && push_ok && sector_last_i;
    assign tc_take   = in_exec && dma_mode_i && tc_i;

    xfr_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (enter),
        .push_i     (push_req),
        .push_data_i(push_data),
        .pop_i      (pop_req),
        .push_ok_o  (push_ok),
        .pop_ok_o   (pop_ok),
        .head_o     (head),
        .cnt_o      (fill_cnt),
        .cnt_next_o (cnt_next),
        .full_o     (full),
        .empty_o    (empty)
    );

    xfr_req_gen #(.DEPTH(DEPTH)) req_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enter_i    (enter),
        .dir_wr_i   (dir_wr_i),
        .thresh_i   (thresh_i),
        .cnt_next_i (cnt_next),
        .last_push_i(last_push),
        .req_o      (req)
    );

    xfr_phase_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .exec_start_i(exec_start_i),
        .tc_take_i   (tc_take),
        .viol_i      (viol),
        .sec_end_i   (sec_end),
        .track_end_i (track_end_i),
        .drained_i   (cnt_next == '0),
        .phase_o     (phase),
        .status_o    (status),
        .ovr_o       (ovr_o),
        .enter_o     (enter)
    );

    always_comb begin
        host_rdata_o = head;
        disk_rdata_o = head;
        irq_o        = xfer_act && !dma_mode_i && req;
        rqm_o        = xfer_act && !dma_mode_i && req;
        drq_o        = xfer_act && dma_mode_i && req;
        result_o     = (phase == PH_RESULT);
        status_o     = status;
    end

endmodule

// File: rtl/thr_xfer_ctrl_chk.sv
module thr_xfer_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          dir_wr_i,
    input logic          exec_start_i,
    input logic          irq_o,
    input logic          rqm_o,
    input logic          drq_o,
    input logic          result_o,
    input logic [1:0]    status_o,
    input logic          ovr_o,
    input logic [CW-1:0] fill_cnt,
    input logic          xfer_act
);

    p_fill_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_cnt <= CW'(DEPTH));

    p_read_empty_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_act && !dir_wr_i && fill_cnt == '0) |-> !(rqm_o || drq_o));

    p_write_full_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_act && dir_wr_i && fill_cnt == CW'(DEPTH)) |-> !(rqm_o || drq_o));

    p_mode_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(drq_o && (irq_o || rqm_o)) && (irq_o == rqm_o));

    p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_o && !exec_start_i) |=> ovr_o);

    p_result_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_o |-> (!irq_o && !rqm_o && !drq_o && status_o != 2'b00));

    p_status_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_o && !exec_start_i) |=> (result_o && $stable(status_o)));

endmodule

bind thr_xfer_ctrl thr_xfer_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_wr_i    (dir_wr_i),
    .exec_start_i(exec_start_i),
    .irq_o       (irq_o),
    .rqm_o       (rqm_o),
    .drq_o       (drq_o),
    .result_o    (result_o),
    .status_o    (status_o),
    .ovr_o       (ovr_o),
    .fill_cnt    (fill_cnt),
    .xfer_act    (xfer_act)
);

// File: tb/thr_xfer_ctrl_tb_top.sv
module thr_xfer_ctrl_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ex = 0, dir = 0, dma = 0, hw = 0, hr = 0, dw = 0, dr = 0, sl = 0, te = 0, tc = 0;
    logic [3:0] thr = 0;
    logic [7:0] hwd = 0, dwd = 0;
    logic [7:0] host_rdata, disk_rdata;
    logic       irq, rqm, drq, res, ovr;
    logic [1:0] status;

    int checks = 0, errors = 0;

    // reference state
    int         m_ph = 0, m_cnt = 0, m_st = 0;
    bit         m_req = 0, m_tcs = 0, m_ovr = 0;
    logic [7:0] m_q[$];

    always #2 clk_i = ~clk_i;

    thr_xfer_ctrl dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .exec_start_i(ex), .dir_wr_i(dir),
        .dma_mode_i(dma), .thresh_i(thr), .host_wr_i(hw), .host_wdata_i(hwd),
        .host_rd_i(hr), .host_rdata_o(host_rdata), .disk_wr_i(dw),
        .disk_wdata_i(dwd), .disk_rd_i(dr), .disk_rdata_o(disk_rdata),
        .sector_last_i(sl), .track_end_i(te), .tc_i(tc), .irq_o(irq),
        .rqm_o(rqm), .drq_o(drq), .result_o(res), .status_o(status), .ovr_o(ovr)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_req(bit ent, bit d, int t, int cn, bit lastp, bit cur);
        if (ent) return d;
        if (!d) begin
            if (cn == 0) return 1'b0;
            if (cn >= 16 - t || lastp) return 1'b1;
            return cur;
        end
        if (cn == 16) return 1'b0;
        if (cn <= t) return 1'b1;
        return cur;
    endfunction

    function automatic int f_term(bit ab, bit tend, bit tcs);
        return (ab || (tend && !tcs)) ? 2 : 1;
    endfunction

    task automatic tick();
        bit in_e  = (m_ph == 1);
        bit act_p = (m_ph == 1) || (m_ph == 2);
        bit ent   = ex && (m_ph == 0 || m_ph == 3);
        bit full  = (m_cnt == 16);
        bit empt  = (m_cnt == 0);
        bit pu    = in_e && (dir ? hw : dw) && !full;
        bit po    = act_p && (dir ? dr : hr) && !empt;
        bit vi    = in_e && (dir ? (hw && full) : (hr && empt));
        bit se    = sl && (dir ? po : pu);
        bit tn    = in_e && dma && tc;
        int cn    = ent ? 0 : m_cnt + int'(pu) - int'(po);
        logic [7:0] pd = dir ? hwd : dwd;
        @(negedge clk_i);
        if (ent) m_q.delete();
        else begin
            if (po) void'(m_q.pop_front());
            if (pu) m_q.push_back(pd);
        end
        m_req = f_req(ent, dir, int'(thr), cn, pu && !dir && sl, m_req);
        case (m_ph)
            0, 3: if (ex) begin m_ph = 1; m_st = 0; m_tcs = 0; m_ovr = 0; end
            1: begin
                m_tcs = m_tcs || tn;
                m_ovr = m_ovr || vi;
                if (se && (m_tcs || m_ovr || te)) begin
                    m_ph = 2;
                    m_st = f_term(m_ovr, te, m_tcs);
                end
            end
            default: if (cn == 0) m_ph = 3;
        endcase
        m_cnt = cn;
        begin
            bit a = (m_ph == 1) || (m_ph == 2);
            chk(dir ? "R5 R6 request" : "R2 R3 R4 request", int'(rqm || drq), int'(a && m_req));
            chk("R7 irq", irq, a && !dma && m_req);
            chk("R7 rqm", rqm, a && !dma && m_req);
            chk("R7 drq", drq, a && dma && m_req);
            chk("R11 result", res, m_ph == 3);
            chk("R8 R9 R10 status", status, m_st);
            chk("R9 ovr flag", ovr, m_ovr);
            chk("R1 occupancy model", m_q.size(), m_cnt);
            if (m_cnt > 0) begin
                chk("R1 host head", host_rdata, m_q[0]);
                chk("R1 disk head", disk_rdata, m_q[0]);
            end
        end
    endtask

    task automatic idle_strobes();
        hw = 0; hr = 0; dw = 0; dr = 0; sl = 0; tc = 0; ex = 0;
    endtask

    task automatic start(bit d, bit m, int t);
        dir = d; dma = m; thr = 4'(t); te = 0;
        idle_strobes();
        ex = 1;
        tick();
        ex = 0;
    endtask

    task automatic run_rand(bit d, bit m, int t, int ph, int pd);
        start(d, m, t);
        for (int i = 0; i < 3000 && m_ph != 3; i++) begin
            hw = ($urandom % 4) < ph; hwd = 8'($urandom);
            hr = ($urandom % 4) < ph;
            dw = ($urandom % 4) < pd; dwd = 8'($urandom);
            dr = ($urandom % 4) < pd;
            sl = (dw || dr) && ($urandom % 10 == 0);
            te = ($urandom % 4 == 0);
            tc = ($urandom % 40 == 0);
            tick();
        end
        idle_strobes();
        tick();
        tick();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk_i);
        // R12 reset state
        chk("R12 irq", irq, 0); chk("R12 rqm", rqm, 0); chk("R12 drq", drq, 0);
        chk("R12 result", res, 0); chk("R12 status", status, 0); chk("R12 ovr", ovr, 0);
        rst_ni = 1;
        tick();

        // directed: disk-to-host, no DMA, thr 4, fill past trigger, EOT close (R2 R10)
        start(0, 0, 4);
        for (int i = 0; i < 12; i++) begin dw = 1; dwd = 8'(i + 1); tick(); end
        chk("R2 trigger at 12", rqm, 1);
        dw = 1; sl = 1; te = 1; dwd = 8'hAA; tick();
        idle_strobes(); te = 0;
        for (int i = 0; i < 14; i++) begin hr = 1; tick(); end
        idle_strobes(); tick();
        chk("R10 abnormal on track end", status, 2);

        // directed: early request on short sector (R3), read-empty underrun (R9)
        start(0, 1, 2);
        dw = 1; dwd = 8'h11; tick();
        dw = 1; sl = 1; dwd = 8'h22; tick();
        chk("R3 last byte raises drq", drq, 1);
        idle_strobes();
        for (int i = 0; i < 3; i++) begin hr = 1; tick(); end
        chk("R9 underrun flag", ovr, 1);
        idle_strobes();
        dw = 1; sl = 1; dwd = 8'h33; tick();
        idle_strobes(); hr = 1; tick(); tick();
        idle_strobes(); tick();
        chk("R9 abnormal after underrun", status, 2);

        // directed: host-to-disk, DMA, thr 3, fill to full, overrun, drain (R5 R6)
        start(1, 1, 3);
        chk("R5 request at start", drq, 1);
        for (int i = 0; i < 17; i++) begin hw = 1; hwd = 8'(8'h40 + i); tick(); end
        chk("R5 cleared at full", drq, 0);
        idle_strobes();
        for (int i = 0; i < 13; i++) begin dr = 1; tick(); end
        chk("R6 reassert at thr", drq, 1);
        idle_strobes(); dr = 1; sl = 1; tick();
        idle_strobes();
        for (int i = 0; i < 3; i++) begin dr = 1; tick(); end
        idle_strobes(); tick();

        // directed: terminal count normal close (R8), tc ignored without DMA
        start(1, 1, 0);
        for (int i = 0; i < 4; i++) begin hw = 1; hwd = 8'(i); tick(); end
        idle_strobes(); tc = 1; tick();
        idle_strobes();
        for (int i = 0; i < 4; i++) begin dr = 1; sl = (i == 3); tick(); end
        idle_strobes(); tick();
        chk("R8 normal status", status, 1);
        start(1, 0, 0);
        hw = 1; hwd = 8'h5A; tick();
        idle_strobes(); tc = 1; tick();
        idle_strobes(); dr = 1; sl = 1; tick();
        idle_strobes(); tick();
        chk("R8 tc ignored without DMA", res, 0);
        hw = 1; tick();
        idle_strobes(); dr = 1; sl = 1; te = 1; tick();
        idle_strobes(); te = 0; tick(); tick();

        // constrained random transfers
        for (int n = 0; n < 60; n++) begin
            run_rand(1'($urandom), 1'($urandom), int'($urandom % 16),
                     1 + int'($urandom % 3), 1 + int'($urandom % 3));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule